// File: doc/BRIEF.md
# Byte-Packet to Memory-Mapped Transaction Converter

This block sits behind a packet de-framer. It accepts request packets as a byte stream, with a start marker on the first byte and an end marker on the last. From each packet it decodes an 8-byte request header and performs 32-bit read or write accesses on a memory-mapped master port. That port carries an address, read and write strobes, write data, read data and a wait handshake. The block then streams a response packet back out, byte by byte.

The header holds three fields in this order:

- an operation code byte;
- a byte that is not used;
- a 16-bit byte count, high byte first.

A 32-bit address follows it, high byte first. A single access touches one word. A sequential access touches count/4 words at addresses that rise by 4.

A read is answered with the raw data words. A write is answered with a short status header that echoes the code with its top bit set, together with the number of bytes written. Codes that the block does not recognise are answered with a fixed no-operation reply and cause no bus traffic.

Top module: `pkt_mm_conv`

## Requirements
- R1: While reset is asserted and after it is released, the outputs are idle until a packet arrives: `in_ready_o`=1, `out_valid_o`=0, `bus_read_o`=0 and `bus_write_o`=0.
- R2: Header byte k (k=0..7) is counted from the byte that carries `in_sop_i`. Byte 0 is the code, byte 1 is ignored, bytes 2..3 are the count (high byte first) and bytes 4..7 are the address (high byte first). Bytes that arrive before a start marker are dropped.
- R3: Code 0x00 performs exactly one bus write at the header address, whatever the count field holds. The write data is built from the next 4 payload bytes, least significant byte first.
- R4: Code 0x04 with a count of at least 4 performs count/4 bus writes, one per 4 payload bytes, at addresses base, base+4, base+8 and so on.
- R5: After a write request, the block emits exactly 4 response bytes: code XOR 0x80, then 0x00, then the high byte and then the low byte of (words written × 4). Start is marked on the first byte and end on the last.
- R6: Code 0x10 performs one bus read at the header address. The response is the 4 bytes of the read word, least significant byte first, with no header. Start is marked on the first byte and end on the fourth.
- R7: Code 0x14 with a count of at least 4 performs count/4 reads at rising addresses, up to at least 256 words. All data bytes are streamed in order, with start marked only on the first byte and end marked only on the last.
- R8: Any other code, and codes 0x04 or 0x14 with a count below 4, cause no bus access. They are answered with the 4 bytes 0xFF, 0x00, 0x00, 0x00.
- R9: While `bus_wait_i` is high, the pending access stays asserted with its address and write data held steady. The access completes in the first cycle in which `bus_wait_i` is low.
- R10: While `out_valid_o`=1 and `out_ready_i`=0, the output byte and its start and end flags stay unchanged.
- R11: A packet whose end marker comes before the eighth header byte is discarded, with no access and no response. A later start marker begins a fresh header.
- R12: `bus_read_o` and `bus_write_o` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | Request byte valid |
| in_ready_o | output | 1 | Request byte accepted when valid |
| in_data_i | input | 8 | Request byte |
| in_sop_i | input | 1 | First byte of a request packet |
| in_eop_i | input | 1 | Last byte of a request packet |
| out_valid_o | output | 1 | Response byte valid |
| out_ready_i | input | 1 | Downstream takes the response byte |
| out_data_o | output | 8 | Response byte |
| out_sop_o | output | 1 | First byte of a response packet |
| out_eop_o | output | 1 | Last byte of a response packet |
| bus_addr_o | output | ADDR_W | Byte address of the access |
| bus_read_o | output | 1 | Read strobe |
| bus_write_o | output | 1 | Write strobe |
| bus_wdata_o | output | 32 | Write data |
| bus_rdata_i | input | 32 | Read data, valid in the cycle the read completes |
| bus_wait_i | input | 1 | Stall of the pending access |

## Verification
The assertions assume a bus slave that returns read data in the same cycle it drops `bus_wait_i`. They also assume that a write request carries exactly the number of payload words its header announces, with no start marker inside the payload. The bench's request builder always emits the payload size derived from the code and count it sends, so stray bytes reach the block only before a start marker, where R2 requires them to be dropped. The bench also sends truncated headers, which R11 requires to be discarded. Stall and backpressure are driven from cycle-counter patterns, so every stalled access and held output byte falls inside the handshake rules that the hold properties encode.

// File: rtl/pmt_pkg.sv
package pmt_pkg;
  localparam int WORD_W     = 32;
  localparam int WORD_BYTES = WORD_W / 8;
  localparam int LANE_W     = $clog2(WORD_BYTES);
  localparam int CNT_W      = 16;
  localparam int HADDR_W    = 32;
  localparam int WORDS_W    = CNT_W - LANE_W;
  localparam int HDR_BYTES  = 8;
  localparam int HDR_IDX_W  = $clog2(HDR_BYTES);

  localparam logic [HDR_IDX_W-1:0] HDR_CNT_FIRST  = HDR_IDX_W'(2);
  localparam logic [HDR_IDX_W-1:0] HDR_ADDR_FIRST = HDR_IDX_W'(4);
  localparam logic [HDR_IDX_W-1:0] HDR_LAST       = HDR_IDX_W'(HDR_BYTES - 1);

  localparam logic [7:0] OP_WR     = 8'h00;
  localparam logic [7:0] OP_WR_SEQ = 8'h04;
  localparam logic [7:0] OP_RD     = 8'h10;
  localparam logic [7:0] OP_RD_SEQ = 8'h14;
  localparam logic [7:0] OP_NONE   = 8'h7F;
  localparam logic [7:0] RSP_FLIP  = 8'h80;

  typedef enum logic [1:0] {K_NONE, K_WR, K_RD} kind_e;
  typedef enum logic [2:0] {S_HDR, S_DEC, S_WDAT, S_WBUS, S_RBUS, S_RTX, S_RSP} state_e;
endpackage

// File: rtl/pmt_hdr_regs.sv
module pmt_hdr_regs
  import pmt_pkg::*;
(
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 we_i,
  input  logic [HDR_IDX_W-1:0] idx_i,
  input  logic [7:0]           byte_i,
  output logic [7:0]           code_o,
  output logic [CNT_W-1:0]     cnt_o,
  output logic [HADDR_W-1:0]   addr_o
);
  // multi-byte fields arrive high byte first: shift in from the bottom
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      code_o <= '0;
      cnt_o  <= '0;
      addr_o <= '0;
    end else if (we_i) begin
      if (idx_i == '0) code_o <= byte_i;
      if (idx_i >= HDR_CNT_FIRST && idx_i < HDR_ADDR_FIRST)
        cnt_o <= {cnt_o[CNT_W-9:0], byte_i};
      if (idx_i >= HDR_ADDR_FIRST)
        addr_o <= {addr_o[HADDR_W-9:0], byte_i};
    end
  end
endmodule

// File: rtl/pmt_decode.sv
module pmt_decode
  import pmt_pkg::*;
(
  input  logic [7:0]         code_i,
  input  logic [CNT_W-1:0]   cnt_i,
  output kind_e              kind_o,
  output logic [WORDS_W-1:0] words_o
);
  logic [WORDS_W-1:0] seq_words;
  logic               unused_low;

  assign seq_words  = cnt_i[CNT_W-1:LANE_W];
  assign unused_low = ^cnt_i[LANE_W-1:0];

  always_comb begin
    kind_o  = K_NONE;
    words_o = '0;
    unique case (code_i)
      OP_WR: begin
        kind_o  = K_WR;
        words_o = WORDS_W'(1);
      end
      OP_RD: begin
        kind_o  = K_RD;
        words_o = WORDS_W'(1);
      end
      OP_WR_SEQ: if (seq_words != '0) begin
        kind_o  = K_WR;
        words_o = seq_words;
      end
      OP_RD_SEQ: if (seq_words != '0) begin
        kind_o  = K_RD;
        words_o = seq_words;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/pkt_mm_conv.sv
module pkt_mm_conv
  import pmt_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              in_valid_i,
  output logic              in_ready_o,
  input  logic [7:0]        in_data_i,
  input  logic              in_sop_i,
  input  logic              in_eop_i,
  output logic              out_valid_o,
  input  logic              out_ready_i,
  output logic [7:0]        out_data_o,
  output logic              out_sop_o,
  output logic              out_eop_o,
  output logic [ADDR_W-1:0] bus_addr_o,
  output logic              bus_read_o,
  output logic              bus_write_o,
  output logic [WORD_W-1:0] bus_wdata_o,
  input  logic [WORD_W-1:0] bus_rdata_i,
  input  logic              bus_wait_i
);
  localparam logic [ADDR_W-1:0] ADDR_STEP = ADDR_W'(WORD_BYTES);

  state_e                state_q;
  logic [HDR_IDX_W-1:0]  hidx_q, hidx_cur;
  logic [LANE_W-1:0]     lane_q;
  logic [WORDS_W-1:0]    left_q, words_q, dec_words;
  logic                  first_q;
  logic [ADDR_W-1:0]     addr_q;
  logic [WORD_W-1:0]     wdata_q, txw_q;
  logic [7:0]            hdr_code;
  logic [CNT_W-1:0]      hdr_cnt;
  logic [HADDR_W-1:0]    hdr_addr;
  logic [CNT_W-1:0]      rsp_cnt;
  kind_e                 dec_kind;
  logic                  in_acc, out_acc, hdr_we, lane_last, word_last, in_rsp;

  assign in_ready_o = (state_q == S_HDR) || (state_q == S_WDAT);
  assign in_acc     = in_valid_i & in_ready_o;
  assign hdr_we     = in_acc & (state_q == S_HDR) & (in_sop_i | (hidx_q != '0));
  assign hidx_cur   = in_sop_i ? '0 : hidx_q;

  assign in_rsp      = (state_q == S_RSP);
  assign out_valid_o = (state_q == S_RTX) || in_rsp;
  assign out_acc     = out_valid_o & out_ready_i;
  assign out_data_o  = txw_q[{lane_q, 3'b000} +: 8];
  assign lane_last   = &lane_q;
  assign word_last   = (left_q == WORDS_W'(1));
  assign out_sop_o   = out_valid_o & (lane_q == '0) & (in_rsp | first_q);
  assign out_eop_o   = out_valid_o & lane_last & (in_rsp | word_last);

  assign bus_read_o  = (state_q == S_RBUS);
  assign bus_write_o = (state_q == S_WBUS);
  assign bus_addr_o  = addr_q;
  assign bus_wdata_o = wdata_q;

  assign rsp_cnt = {words_q, {LANE_W{1'b0}}};

  pmt_hdr_regs u_hdr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .we_i   (hdr_we),
    .idx_i  (hidx_cur),
    .byte_i (in_data_i),
    .code_o (hdr_code),
    .cnt_o  (hdr_cnt),
    .addr_o (hdr_addr)
  );

  pmt_decode u_dec (
    .code_i  (hdr_code),
    .cnt_i   (hdr_cnt),
    .kind_o  (dec_kind),
    .words_o (dec_words)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= S_HDR;
      hidx_q  <= '0;
      lane_q  <= '0;
      left_q  <= '0;
      words_q <= '0;
      first_q <= 1'b0;
      addr_q  <= '0;
      wdata_q <= '0;
      txw_q   <= '0;
    end else begin
      unique case (state_q)
        S_HDR: if (hdr_we) begin
          if (hidx_cur == HDR_LAST) begin
            hidx_q  <= '0;
            state_q <= S_DEC;
          end else if (in_eop_i) begin
            hidx_q <= '0;                 // truncated header: drop packet
          end else begin
            hidx_q <= hidx_cur + 1'b1;
          end
        end
        S_DEC: begin
          addr_q  <= hdr_addr[ADDR_W-1:0];
          left_q  <= dec_words;
          words_q <= dec_words;
          lane_q  <= '0;
          first_q <= 1'b1;
          unique case (dec_kind)
            K_WR:    state_q <= S_WDAT;
            K_RD:    state_q <= S_RBUS;
            default: begin
              txw_q   <= {8'h00, 8'h00, 8'h00, OP_NONE ^ RSP_FLIP};
              state_q <= S_RSP;
            end
          endcase
        end
        S_WDAT: if (in_acc) begin
          wdata_q <= {in_data_i, wdata_q[WORD_W-1:8]};
          lane_q  <= lane_q + 1'b1;
          if (lane_last) state_q <= S_WBUS;
        end
        S_WBUS: if (!bus_wait_i) begin
          addr_q <= addr_q + ADDR_STEP;
          left_q <= left_q - 1'b1;
          if (word_last) begin
            txw_q   <= {rsp_cnt[7:0], rsp_cnt[15:8], 8'h00, hdr_code ^ RSP_FLIP};
            state_q <= S_RSP;
          end else begin
            state_q <= S_WDAT;
          end
        end
        S_RBUS: if (!bus_wait_i) begin
          txw_q   <= bus_rdata_i;
          addr_q  <= addr_q + ADDR_STEP;
          state_q <= S_RTX;
        end
        S_RTX: if (out_acc) begin
          lane_q <= lane_q + 1'b1;
          if (lane_last) begin
            first_q <= 1'b0;
            left_q  <= left_q - 1'b1;
            state_q <= word_last ? S_HDR : S_RBUS;
          end
        end
        S_RSP: if (out_acc) begin
          lane_q <= lane_q + 1'b1;
          if (lane_last) state_q <= S_HDR;
        end
        default: state_q <= S_HDR;
      endcase
    end
  end
endmodule

// File: rtl/pmt_conv_chk.sv
module pmt_conv_chk #(
  parameter int ADDR_W = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              out_valid_o,
  input logic              out_ready_i,
  input logic [7:0]        out_data_o,
  input logic              out_sop_o,
  input logic              out_eop_o,
  input logic [ADDR_W-1:0] bus_addr_o,
  input logic              bus_read_o,
  input logic              bus_write_o,
  input logic [31:0]       bus_wdata_o,
  input logic              bus_wait_i
);
  // R12
  rd_wr_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(bus_read_o && bus_write_o));

  // R9
  wr_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_write_o && bus_wait_i) |=> (bus_write_o && $stable(bus_addr_o) && $stable(bus_wdata_o)));

  // R9
  rd_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_read_o && bus_wait_i) |=> (bus_read_o && $stable(bus_addr_o)));

  // R10
  out_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && !out_ready_i) |=>
      (out_valid_o && $stable(out_data_o) && $stable(out_sop_o) && $stable(out_eop_o)));

  // R6
  rd_once_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_read_o && !bus_wait_i) |=> !bus_read_o);
endmodule

bind pkt_mm_conv pmt_conv_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .out_valid_o (out_valid_o),
  .out_ready_i (out_ready_i),
  .out_data_o  (out_data_o),
  .out_sop_o   (out_sop_o),
  .out_eop_o   (out_eop_o),
  .bus_addr_o  (bus_addr_o),
  .bus_read_o  (bus_read_o),
  .bus_write_o (bus_write_o),
  .bus_wdata_o (bus_wdata_o),
  .bus_wait_i  (bus_wait_i)
);

// File: tb/pkt_mm_conv_bench.sv
module pkt_mm_conv_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid, in_ready, in_sop, in_eop;
  logic [7:0]  in_data;
  logic        out_valid, out_ready, out_sop, out_eop;
  logic [7:0]  out_data;
  logic [31:0] bus_addr, bus_wdata, bus_rdata;
  logic        bus_read, bus_write, bus_wait;

  always #10 clk = ~clk;

  pkt_mm_conv u_pkt_mm_conv (
    .clk_i(clk), .rst_ni(rst_n),
    .in_valid_i(in_valid), .in_ready_o(in_ready), .in_data_i(in_data),
    .in_sop_i(in_sop), .in_eop_i(in_eop),
    .out_valid_o(out_valid), .out_ready_i(out_ready), .out_data_o(out_data),
    .out_sop_o(out_sop), .out_eop_o(out_eop),
    .bus_addr_o(bus_addr), .bus_read_o(bus_read), .bus_write_o(bus_write),
    .bus_wdata_o(bus_wdata), .bus_rdata_i(bus_rdata), .bus_wait_i(bus_wait)
  );

  logic [31:0] mem [0:1023];
  logic [31:0] acc_addr [0:4095];
  logic [7:0]  rx_b [0:4095];
  bit          rx_s [0:4095];
  bit          rx_e [0:4095];
  int cyc = 0, wr_cnt = 0, rd_cnt = 0, acc_n = 0, rx_n = 0, ovl = 0;
  int vec = 0, miss = 0;
  bit wmode = 0, rmode = 0;

  assign bus_rdata = mem[bus_addr[11:2]];

  // slave model and response sink, updated away from the active edge
  always @(negedge clk) begin
    cyc++;
    bus_wait  = wmode && ((cyc % 5) < 2);
    out_ready = !rmode || ((cyc % 3) != 0);
    if (!rst_n) begin
      for (int i = 0; i < 1024; i++) mem[i] = 32'(i) * 32'h9E37_79B1;
    end else begin
      if (bus_read && bus_write) ovl++;
      if (bus_write && !bus_wait) begin
        mem[bus_addr[11:2]] = bus_wdata;
        acc_addr[acc_n & 4095] = bus_addr;
        acc_n++;
        wr_cnt++;
      end
      if (bus_read && !bus_wait) begin
        acc_addr[acc_n & 4095] = bus_addr;
        acc_n++;
        rd_cnt++;
      end
      if (out_valid && out_ready) begin
        rx_b[rx_n & 4095] = out_data;
        rx_s[rx_n & 4095] = out_sop;
        rx_e[rx_n & 4095] = out_eop;
        rx_n++;
      end
    end
  end

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    vec++;
    if (!ok) begin
      miss++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] wval(input logic [31:0] a, input int i);
    return (a + 32'(4 * i)) * 32'h0101_0101 ^ 32'h7A4D_7B4A;
  endfunction

  // called just after a falling edge; returns just after a falling edge
  task automatic put_byte(input logic [7:0] b, input bit s, input bit e);
    in_data = b; in_sop = s; in_eop = e; in_valid = 1'b1;
    while (!in_ready) @(negedge clk);
    @(negedge clk);
    in_valid = 1'b0; in_sop = 1'b0; in_eop = 1'b0;
  endtask

  task automatic do_case(input logic [7:0] code, input logic [15:0] cnt,
                         input logic [31:0] base, input bit junk);
    bit isw, isr;
    int nw, exp_n, rx0, ac0, wr0, rd0, idx;
    logic [31:0] w;
    logic [7:0] eb;
    string tg, rt;
    isw = 0; isr = 0; nw = 0; tg = "R8";
    case (code)
      8'h00: begin isw = 1; nw = 1; tg = "R3"; end
      8'h10: begin isr = 1; nw = 1; tg = "R6"; end
      8'h04: if (cnt >= 4) begin isw = 1; nw = cnt / 4; tg = "R4"; end
      8'h14: if (cnt >= 4) begin isr = 1; nw = cnt / 4; tg = "R7"; end
      default: ;
    endcase
    if (wmode) tg = {tg, "/R9"};
    if (rmode) tg = {tg, "/R10"};
    rt = isw ? {tg, "/R5"} : tg;
    rx0 = rx_n; ac0 = acc_n; wr0 = wr_cnt; rd0 = rd_cnt;
    if (junk) begin            // R2: bytes ahead of the start marker are dropped
      put_byte(8'h3C, 0, 0);
      put_byte(8'h7B, 0, 1);
    end
    put_byte(code, 1, 0);
    put_byte(8'hA5, 0, 0);
    put_byte(cnt[15:8], 0, 0);
    put_byte(cnt[7:0], 0, 0);
    put_byte(base[31:24], 0, 0);
    put_byte(base[23:16], 0, 0);
    put_byte(base[15:8], 0, 0);
    put_byte(base[7:0], 0, !isw);
    if (isw)
      for (int i = 0; i < nw; i++) begin
        w = wval(base, i);
        for (int b = 0; b < 4; b++) put_byte(w[8*b +: 8], 0, (i == nw - 1) && (b == 3));
      end
    exp_n = isr ? 4 * nw : 4;
    for (int t = 0; t < 20000 && (rx_n - rx0) < exp_n; t++) @(negedge clk);
    repeat (10) @(negedge clk);
    chk((rx_n - rx0) == exp_n, rt, rx_n - rx0, exp_n);
    for (int k = 0; k < exp_n; k++) begin
      idx = (rx0 + k) & 4095;
      if (isr) begin
        w  = mem[(int'(base[11:2]) + k / 4) & 1023];
        eb = w[8*(k%4) +: 8];
      end else begin
        case (k)
          0: eb = isw ? (code ^ 8'h80) : 8'hFF;
          2: eb = isw ? 8'((4 * nw) >> 8) : 8'h00;
          3: eb = isw ? 8'(4 * nw) : 8'h00;
          default: eb = 8'h00;
        endcase
      end
      chk(rx_b[idx] == eb && rx_s[idx] == (k == 0) && rx_e[idx] == (k == exp_n - 1), rt,
          {rx_s[idx], rx_e[idx], rx_b[idx]}, {(k == 0), (k == exp_n - 1), eb});
    end
    chk((wr_cnt - wr0) == (isw ? nw : 0), tg, wr_cnt - wr0, isw ? nw : 0);
    chk((rd_cnt - rd0) == (isr ? nw : 0), tg, rd_cnt - rd0, isr ? nw : 0);
    for (int k = 0; k < nw; k++) begin
      w = base + 32'(4 * k);
      chk(acc_addr[(ac0 + k) & 4095] == w, {tg, "/R2"}, acc_addr[(ac0 + k) & 4095], w);
    end
    if (isw)
      for (int k = 0; k < nw; k++) begin
        w = mem[(int'(base[11:2]) + k) & 1023];
        chk(w == wval(base, k), tg, w, wval(base, k));
      end
  endtask

  initial begin
    logic [7:0]  codes [0:5];
    logic [15:0] cnts  [0:4];
    int n, rx0, rd0;
    codes = '{8'h00, 8'h04, 8'h10, 8'h14, 8'h7F, 8'h33};
    cnts  = '{16'd4, 16'd8, 16'd12, 16'd0, 16'd2};
    in_valid = 0; in_sop = 0; in_eop = 0; in_data = 0;
    repeat (3) @(negedge clk);
    // R1: state held in reset
    chk(in_ready && !out_valid && !bus_read && !bus_write, "R1 reset",
        {in_ready, out_valid, bus_read, bus_write}, 4'b1000);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(in_ready && !out_valid && !bus_read && !bus_write, "R1 idle",
        {in_ready, out_valid, bus_read, bus_write}, 4'b1000);

    n = 0;
    for (int m = 0; m < 4; m++) begin
      wmode = m[0]; rmode = m[1];
      for (int c = 0; c < 6; c++)
        for (int q = 0; q < 5; q++) begin
          do_case(codes[c], cnts[q], 32'h5A00_0000 | 32'((n * 48) % 3072), (n % 7) == 3);
          n++;
        end
    end

    // R5: count high byte nonzero; R7: longest sequential read
    wmode = 1; rmode = 1;
    do_case(8'h04, 16'd280, 32'hC3C3_0800, 0);
    do_case(8'h14, 16'd1024, 32'h0123_0100, 0);

    // R11: truncated header is dropped, no access and no reply
    wmode = 0; rmode = 0;
    rx0 = rx_n; rd0 = rd_cnt;
    put_byte(8'h10, 1, 0);
    put_byte(8'h00, 0, 0);
    put_byte(8'h00, 0, 1);
    repeat (30) @(negedge clk);
    chk(rx_n == rx0 && rd_cnt == rd0 && in_ready, "R11 truncated",
        {rx_n - rx0, rd_cnt - rd0}, 0);
    // R11: restart of a header by a new start marker
    put_byte(8'h04, 1, 0);
    put_byte(8'h00, 0, 0);
    put_byte(8'h00, 0, 0);
    do_case(8'h10, 16'd4, 32'h0000_0040, 0);

    // R12
    chk(ovl == 0, "R12 read/write overlap", ovl, 0);

    $display("== %0d vectors applied, %0d miscompares ==", vec, miss);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    vec++; miss++;
    $display("FAIL watchdog act=%0h exp=%0h", 1, 0);
    $display("== %0d vectors applied, %0d miscompares ==", vec, miss);
    $finish;
  end
endmodule